// File: doc/BRIEF.md
# Packed Status-Mask Interrupt Controller

This block gathers event pulses from three sources into sticky status bits and drives one level interrupt request line per source. The first source has up to half a data word of channels. Its status bits and its enable bits share one register word: status in the low half, enables in the high half. The second source keeps its status and its enable bits in two separate registers. The third source is a plain flag group with no enable bits at all.

Software reads all state through a combinational read port. It acknowledges events by writing ones to the status bits it has serviced. In the packed word, a one written in the upper half flips the matching enable bit, so a single write can both acknowledge channels and change their enables. Each request line is a registered level that follows the OR of the enabled status bits one clock later. A new event always wins over a clear of the same bit in the same cycle, so no event is lost.

Register select encoding on `reg_addr`: 0 is the packed word, 1 is the general status, 2 is the general enable, 3 is the flag group. Narrower registers read back zero-extended.

Top module: `irq_hub`

## Requirements
- R1: After reset, every status, enable and flag bit is 0, all three request lines are low, and every register reads as 0.
- R2: A high bit on `dma_evt`, `gen_evt` or `flg_evt` during a clock edge sets the matching status or flag bit, and the bit is readable after that edge.
- R3: A write to address 0 clears each status bit in [15:0] whose written bit is 1 and leaves the other status bits unchanged.
- R4: A write to address 0 inverts each enable bit in [31:16] whose written bit is 1 and leaves the others unchanged. Enable bits change only on writes to address 0.
- R5: `dma_irq` is high exactly one cycle after a cycle in which (status[15:0] AND enable[31:16]) of the packed word is non-zero. It is low otherwise.
- R6: A write to address 1 clears each general status bit whose written bit is 1 and leaves the others unchanged.
- R7: Address 2 is a plain read/write enable register. `gen_irq` is high one cycle after (general status AND general enable) is non-zero, and low one cycle after it becomes zero.
- R8: A write to address 3 clears each flag whose written bit is 1. `flg_irq` is high one cycle after any flag is set, with no enable, and low one cycle after all flags are zero.
- R9: When an event and a clearing write hit the same status or flag bit in one cycle, the bit ends set.
- R10: A write changes only the register that is selected. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | 2 | Register select (0 packed, 1 general status, 2 general enable, 3 flags) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of the selected register |
| dma_evt | input | DATA_W/2 | Event pulses for the packed-word channels |
| gen_evt | input | GEN_W | Event pulses for the general status bits |
| flg_evt | input | FLG_W | Event pulses for the flag group |
| dma_irq | output | 1 | Registered request of the packed-word group |
| gen_irq | output | 1 | Registered request of the general group |
| flg_irq | output | 1 | Registered request of the flag group |

## Verification
Status, enable and flag state changes on the edge that takes the event or the write, so the read port shows it from that edge onward. Each request line needs one more edge. The bench drives on falling edges and reads the register contents at the first falling edge after the edge that takes the stimulus. At that same point it checks that the request line still shows the old value. It then reads the line again one falling edge later for the new value. Simultaneous event-and-clear cases are driven inside a single write cycle, and the result is read at the next falling edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   typedef enum logic [1:0] {
      SEL_PACKED = 2'd0,
      SEL_GSTAT  = 2'd1,
      SEL_GMASK  = 2'd2,
      SEL_FLAGS  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);

   logic [W-1:0] stat_q;

   // a set in the same cycle as a clear leaves the bit set
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_i) | set_i;
   end

   assign stat_o = stat_q;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int W      = 16,
   parameter bit TOGGLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);

   logic [W-1:0] mask_q;
   logic [W-1:0] mask_d;

   generate
      if (TOGGLE) begin : g_toggle
         always_comb mask_d = we_i ? (mask_q ^ wdata_i) : mask_q;
      end else begin : g_plain
         always_comb mask_d = we_i ? wdata_i : mask_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/irq_line.sv
module irq_line #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_i & mask_i);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
   parameter int DATA_W = 32,
   parameter int GEN_W  = 16,
   parameter int FLG_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [1:0]            reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [DATA_W/2-1:0]   dma_evt,
   input  logic [GEN_W-1:0]      gen_evt,
   input  logic [FLG_W-1:0]      flg_evt,
   output logic                  dma_irq,
   output logic                  gen_irq,
   output logic                  flg_irq
);
   import irq_hub_pkg::*;

   localparam int DMA_N = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("irq_hub: DATA_W must be even");
      end
      if (GEN_W < 1 || GEN_W > DATA_W) begin : g_bad_gen
         $error("irq_hub: GEN_W must be in 1..DATA_W");
      end
      if (FLG_W < 1 || FLG_W > DATA_W) begin : g_bad_flg
         $error("irq_hub: FLG_W must be in 1..DATA_W");
      end
   endgenerate

   // write decode
   logic wr_packed, wr_gstat, wr_gmask, wr_flags;
   assign wr_packed = reg_wr && (reg_addr == SEL_PACKED);
   assign wr_gstat  = reg_wr && (reg_addr == SEL_GSTAT);
   assign wr_gmask  = reg_wr && (reg_addr == SEL_GMASK);
   assign wr_flags  = reg_wr && (reg_addr == SEL_FLAGS);

   logic [DMA_N-1:0] dma_clr;
   logic [GEN_W-1:0] gen_clr;
   logic [FLG_W-1:0] flg_clr;
   assign dma_clr = wr_packed ? reg_wdata[DMA_N-1:0] : '0;
   assign gen_clr = wr_gstat  ? reg_wdata[GEN_W-1:0] : '0;
   assign flg_clr = wr_flags  ? reg_wdata[FLG_W-1:0] : '0;

   logic [DMA_N-1:0] dma_stat, dma_mask;
   logic [GEN_W-1:0] gen_stat, gen_mask;
   logic [FLG_W-1:0] flg_stat;

   // packed word: status bank and toggled enables
   irq_stat_bank #(.W(DMA_N)) u_dma_stat (
      .clk(clk), .rst_n(rst_n), .set_i(dma_evt), .clr_i(dma_clr), .stat_o(dma_stat));

   irq_mask_reg #(.W(DMA_N), .TOGGLE(1'b1)) u_dma_mask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_packed),
      .wdata_i(reg_wdata[DATA_W-1:DMA_N]), .mask_o(dma_mask));

   irq_line #(.W(DMA_N)) u_dma_line (
      .clk(clk), .rst_n(rst_n), .stat_i(dma_stat), .mask_i(dma_mask), .irq_o(dma_irq));

   // general group: status bank and plain enables
   irq_stat_bank #(.W(GEN_W)) u_gen_stat (
      .clk(clk), .rst_n(rst_n), .set_i(gen_evt), .clr_i(gen_clr), .stat_o(gen_stat));

   irq_mask_reg #(.W(GEN_W), .TOGGLE(1'b0)) u_gen_mask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_gmask),
      .wdata_i(reg_wdata[GEN_W-1:0]), .mask_o(gen_mask));

   irq_line #(.W(GEN_W)) u_gen_line (
      .clk(clk), .rst_n(rst_n), .stat_i(gen_stat), .mask_i(gen_mask), .irq_o(gen_irq));

   // flag group: no enables
   irq_stat_bank #(.W(FLG_W)) u_flg_stat (
      .clk(clk), .rst_n(rst_n), .set_i(flg_evt), .clr_i(flg_clr), .stat_o(flg_stat));

   irq_line #(.W(FLG_W)) u_flg_line (
      .clk(clk), .rst_n(rst_n), .stat_i(flg_stat), .mask_i({FLG_W{1'b1}}), .irq_o(flg_irq));

   // read mux, no side effects
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_PACKED: reg_rdata = {dma_mask, dma_stat};
         SEL_GSTAT:  reg_rdata[GEN_W-1:0] = gen_stat;
         SEL_GMASK:  reg_rdata[GEN_W-1:0] = gen_mask;
         default:    reg_rdata[FLG_W-1:0] = flg_stat;
      endcase
   end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
   parameter int DATA_W = 32,
   parameter int GEN_W  = 16,
   parameter int FLG_W  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [1:0]          reg_addr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic [DATA_W/2-1:0] dma_evt,
   input logic [GEN_W-1:0]    gen_evt,
   input logic [DATA_W/2-1:0] dma_stat,
   input logic [DATA_W/2-1:0] dma_mask,
   input logic [GEN_W-1:0]    gen_stat,
   input logic [GEN_W-1:0]    gen_mask,
   input logic [FLG_W-1:0]    flg_stat,
   input logic                dma_irq,
   input logic                flg_irq
);
   import irq_hub_pkg::*;
   localparam int DMA_N = DATA_W / 2;

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|dma_evt) |=> ((dma_stat & $past(dma_evt)) == $past(dma_evt))); // R9

   AST_PACKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SEL_PACKED) |=>
      ((dma_stat & $past(reg_wdata[DMA_N-1:0] & ~dma_evt)) == '0)); // R3

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == SEL_PACKED) |=> $stable(dma_mask)); // R4

   AST_DMA_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      dma_irq |-> $past(|(dma_stat & dma_mask))); // R5

   AST_GSTAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SEL_GSTAT) |=>
      ((gen_stat & $past(reg_wdata[GEN_W-1:0] & ~gen_evt)) == '0)); // R6

   AST_GMASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SEL_GMASK) |=> (gen_mask == $past(reg_wdata[GEN_W-1:0]))); // R7

   AST_FLAG_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      flg_irq |-> $past(|flg_stat)); // R8

endmodule

bind irq_hub irq_hub_chk #(.DATA_W(DATA_W), .GEN_W(GEN_W), .FLG_W(FLG_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .dma_evt(dma_evt), .gen_evt(gen_evt),
   .dma_stat(dma_stat), .dma_mask(dma_mask), .gen_stat(gen_stat),
   .gen_mask(gen_mask), .flg_stat(flg_stat), .dma_irq(dma_irq), .flg_irq(flg_irq));

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] dma_evt = '0;
   logic [15:0] gen_evt = '0;
   logic [7:0]  flg_evt = '0;
   logic        dma_irq, gen_irq, flg_irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   irq_hub dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_evt(dma_evt),
      .gen_evt(gen_evt), .flg_evt(flg_evt), .dma_irq(dma_irq),
      .gen_irq(gen_irq), .flg_irq(flg_irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   // one write (with optional events) taken on the next rising edge; returns at the following falling edge
   task automatic wr_evt(input logic [1:0] a, input logic [31:0] d,
                         input logic [15:0] de, input logic [15:0] ge, input logic [7:0] fe);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      dma_evt = de; gen_evt = ge; flg_evt = fe;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; dma_evt = '0; gen_evt = '0; flg_evt = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_evt(a, d, '0, '0, '0);
   endtask

   task automatic pulse(input logic [15:0] de, input logic [15:0] ge, input logic [7:0] fe);
      dma_evt = de; gen_evt = ge; flg_evt = fe;
      @(negedge clk);
      dma_evt = '0; gen_evt = '0; flg_evt = '0;
   endtask

   task automatic t_reset();
      rd_chk("R1 packed", 2'd0, 32'h0);
      rd_chk("R1 gstat", 2'd1, 32'h0);
      rd_chk("R1 gmask", 2'd2, 32'h0);
      rd_chk("R1 flags", 2'd3, 32'h0);
      chk("R1 irqs", {29'd0, dma_irq, gen_irq, flg_irq}, 32'h0);
   endtask

   task automatic t_packed();
      pulse(16'h0005, '0, '0);
      rd_chk("R2 packed set", 2'd0, 32'h0000_0005);
      @(negedge clk);
      chk("R5 masked off", {31'd0, dma_irq}, 32'd0);
      wr(2'd0, 32'h0001_0000);
      rd_chk("R4 toggle on", 2'd0, 32'h0001_0005);
      chk("R5 not yet", {31'd0, dma_irq}, 32'd0);
      @(negedge clk);
      chk("R5 raised", {31'd0, dma_irq}, 32'd1);
      wr(2'd0, 32'h0000_0001);
      rd_chk("R3 clear bit0", 2'd0, 32'h0001_0004);
      chk("R5 still high", {31'd0, dma_irq}, 32'd1);
      @(negedge clk);
      chk("R5 dropped", {31'd0, dma_irq}, 32'd0);
      wr(2'd0, 32'h0005_0000);
      rd_chk("R4 toggle two", 2'd0, 32'h0004_0004);
      @(negedge clk);
      chk("R5 bit2 enabled", {31'd0, dma_irq}, 32'd1);
      wr(2'd0, 32'h0004_0004);
      rd_chk("R3 R4 combined", 2'd0, 32'h0);
      @(negedge clk);
      chk("R5 low again", {31'd0, dma_irq}, 32'd0);
   endtask

   task automatic t_general();
      pulse('0, 16'h0300, '0);
      rd_chk("R2 gstat set", 2'd1, 32'h0000_0300);
      wr(2'd2, 32'h0000_0100);
      rd_chk("R7 gmask rw", 2'd2, 32'h0000_0100);
      chk("R7 not yet", {31'd0, gen_irq}, 32'd0);
      @(negedge clk);
      chk("R7 raised", {31'd0, gen_irq}, 32'd1);
      wr(2'd1, 32'h0000_0100);
      rd_chk("R6 clear bit8", 2'd1, 32'h0000_0200);
      @(negedge clk);
      chk("R7 dropped", {31'd0, gen_irq}, 32'd0);
      wr(2'd1, 32'h0000_0200);
      rd_chk("R6 clear bit9", 2'd1, 32'h0);
      wr(2'd2, 32'h0);
      rd_chk("R7 gmask zero", 2'd2, 32'h0);
   endtask

   task automatic t_flags();
      pulse('0, '0, 8'h81);
      rd_chk("R2 flags set", 2'd3, 32'h0000_0081);
      chk("R8 not yet", {31'd0, flg_irq}, 32'd0);
      @(negedge clk);
      chk("R8 raised", {31'd0, flg_irq}, 32'd1);
      wr(2'd3, 32'h0000_0001);
      rd_chk("R8 clear one", 2'd3, 32'h0000_0080);
      @(negedge clk);
      chk("R8 one flag left", {31'd0, flg_irq}, 32'd1);
      wr(2'd3, 32'h0000_0080);
      rd_chk("R8 all clear", 2'd3, 32'h0);
      @(negedge clk);
      chk("R8 dropped", {31'd0, flg_irq}, 32'd0);
   endtask

   task automatic t_race();
      pulse(16'h0008, 16'h0008, 8'h08);
      wr_evt(2'd0, 32'h0000_0008, 16'h0008, '0, '0);
      rd_chk("R9 packed evt wins", 2'd0, 32'h0000_0008);
      wr_evt(2'd1, 32'h0000_0008, '0, 16'h0008, '0);
      rd_chk("R9 gstat evt wins", 2'd1, 32'h0000_0008);
      wr_evt(2'd3, 32'h0000_0008, '0, '0, 8'h08);
      rd_chk("R9 flag evt wins", 2'd3, 32'h0000_0008);
      wr(2'd0, 32'h0000_0008);
      wr(2'd1, 32'h0000_0008);
      wr(2'd3, 32'h0000_0008);
      rd_chk("R3 race cleanup", 2'd0, 32'h0);
   endtask

   task automatic t_isolation();
      pulse(16'h0010, 16'h0010, 8'h10);
      wr(2'd2, 32'h0000_0010);
      wr(2'd3, 32'hFFFF_FFFF);
      rd_chk("R10 packed untouched", 2'd0, 32'h0000_0010);
      rd_chk("R10 gstat untouched", 2'd1, 32'h0000_0010);
      rd_chk("R10 gmask untouched", 2'd2, 32'h0000_0010);
      rd_chk("R10 flags cleared", 2'd3, 32'h0);
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk("R10 gstat after packed wr", 2'd1, 32'h0000_0010);
      rd_chk("R10 gmask after packed wr", 2'd2, 32'h0000_0010);
      rd_chk("R4 all toggled", 2'd0, 32'hFFFF_0000);
      @(negedge clk);
      rd_chk("R10 read repeat", 2'd1, 32'h0000_0010);
      chk("R10 gen irq live", {31'd0, gen_irq}, 32'd1);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_packed();
      t_general();
      t_flags();
      t_race();
      t_isolation();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule